// File: doc/BRIEF.md
# Reference-Pulse Oscillator Edge Counter

This block measures the frequency of an external oscillator of roughly 10 MHz against a once-per-second timing pulse from a satellite receiver. It counts every rising edge of the oscillator with a counter that keeps running from reset onward and is never stopped, cleared or reloaded. Each time the reference pulse rises, the block takes a snapshot of that counter. It reports the number of oscillator edges seen since the previous snapshot as the unsigned difference between the two captures. The counter is never interrupted, so edges that land between two intervals are always counted in one of them.

Neither input is related to the system clock, so each one passes through its own two-flop synchronizer before edge detection. The oscillator edges are counted in the system clock domain. The system clock must therefore run several times faster than the oscillator, and each oscillator level must last at least two system clocks. For longer averaging, a second stage adds up a parameterized number of consecutive per-second results and strobes the total separately.

Top module: `pps_edge_counter`

## Requirements
- R1: The running counter advances by exactly one for each synchronized rising edge of `osc_in`. It does not change otherwise and returns to zero only on reset.
- R2: A capture happens only when `pps_in` goes from low to high. Holding `pps_in` high, even while oscillator edges arrive, produces no further capture until `pps_in` has been low again.
- R3: `sec_count` equals the new capture minus the previous capture, modulo 2^CNT_W. With CNT_W = 8 and 300 edges in an interval, the result is 44.
- R4: No oscillator edge is lost between intervals. Edges that arrive while `pps_in` is high after a capture are reported in the next interval, and an interval with no edges reports 0.
- R5: `sec_valid` is a single-cycle pulse. It is high in the cycle after the third rising clock edge at which `pps_in` is sampled high, so the capture latency is a fixed three system clocks.
- R6: The first capture after reset only loads the previous-capture register and raises no `sec_valid`. Every later capture raises `sec_valid`.
- R7: `span_sum` is the sum of SPAN consecutive `sec_count` results. `span_valid` pulses for one cycle, one cycle after the SPAN-th `sec_valid`, and the sum then starts again from zero.
- R8: While reset is held and directly after it, `sec_count`, `span_sum`, `sec_valid` and `span_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the oscillator rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_in | input | 1 | Oscillator signal whose rising edges are counted (asynchronous) |
| pps_in | input | 1 | Once-per-second reference pulse (asynchronous) |
| sec_count | output | CNT_W | Edges counted between the last two captures |
| sec_valid | output | 1 | One-cycle strobe when `sec_count` is updated |
| span_sum | output | SUM_W | Sum of SPAN consecutive per-interval counts |
| span_valid | output | 1 | One-cycle strobe when `span_sum` is updated |

## Verification
The bench drives intervals of different lengths between reference rises: a typical count, a single edge, no edges at all, and a count large enough to wrap an 8-bit counter instance. Together these separate a correct modular difference from an off-by-one count and from a lost edge at an interval boundary.

Some reference pulses are held high for a long time while oscillator edges keep arriving. These show whether a level, rather than an edge, starts a capture, and whether edges counted during the high phase move into the next interval.

Every capture is timed against the three-clock latency, and the accumulated sums are compared at two span lengths, which checks when the averaging stage restarts.

// File: rtl/pps_edge_counter.sv
module pps_edge_counter #(
  parameter int CNT_W = 32,
  parameter int SPAN  = 10,
  parameter int SUM_W = CNT_W + $clog2(SPAN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_in,
  input  logic             pps_in,
  output logic [CNT_W-1:0] sec_count,
  output logic             sec_valid,
  output logic [SUM_W-1:0] span_sum,
  output logic             span_valid
);

  localparam int IDX_W = (SPAN > 1) ? $clog2(SPAN) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SPAN - 1);

  logic             osc_s1, osc_s2, osc_d;
  logic             pps_s1, pps_s2, pps_d;
  logic             osc_rise, pps_rise;
  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] cap_prev;
  logic             primed;
  logic [SUM_W-1:0] acc;
  logic [IDX_W-1:0] idx;

  assign osc_rise = osc_s2 & ~osc_d;
  assign pps_rise = pps_s2 & ~pps_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {osc_s1, osc_s2, osc_d} <= '0;
      {pps_s1, pps_s2, pps_d} <= '0;
    end else begin
      {osc_s1, osc_s2, osc_d} <= {osc_in, osc_s1, osc_s2};
      {pps_s1, pps_s2, pps_d} <= {pps_in, pps_s1, pps_s2};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= '0;
    else if (osc_rise) run_cnt <= run_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_prev  <= '0;
      primed    <= 1'b0;
      sec_count <= '0;
      sec_valid <= 1'b0;
    end else begin
      sec_valid <= 1'b0;
      if (pps_rise) begin
        cap_prev <= run_cnt;
        primed   <= 1'b1;
        if (primed) begin
          sec_count <= run_cnt - cap_prev;
          sec_valid <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc        <= '0;
      idx        <= '0;
      span_sum   <= '0;
      span_valid <= 1'b0;
    end else begin
      span_valid <= 1'b0;
      if (sec_valid) begin
        if (idx == LAST_IDX) begin
          span_sum   <= acc + SUM_W'(sec_count);
          span_valid <= 1'b1;
          acc        <= '0;
          idx        <= '0;
        end else begin
          acc <= acc + SUM_W'(sec_count);
          idx <= idx + 1'b1;
        end
      end
    end
  end

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    osc_rise |=> run_cnt == $past(run_cnt) + 1'b1);

  assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_rise |=> $stable(run_cnt));

  assert_edge_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pps_rise |=> !pps_rise);

  assert_strobe_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sec_valid |=> !sec_valid);

  assert_primed_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sec_valid |-> $past(primed));

  assert_span_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    span_valid |-> $past(sec_valid));

endmodule

// File: tb/tb_pps_edge_counter.sv
module tb_pps_edge_counter;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_in = 1'b0;
  logic pps_in = 1'b0;

  logic [31:0] sec_count;
  logic        sec_valid;
  logic [34:0] span_sum;
  logic        span_valid;
  logic [7:0]  w8_count;
  logic        w8_valid;
  logic [9:0]  w8_sum;
  logic        w8_span_valid;

  always #10 clk = ~clk;

  pps_edge_counter #(.CNT_W(32), .SPAN(4)) dut (
    .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .pps_in(pps_in),
    .sec_count(sec_count), .sec_valid(sec_valid),
    .span_sum(span_sum), .span_valid(span_valid));

  pps_edge_counter #(.CNT_W(8), .SPAN(2)) dut_w8 (
    .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .pps_in(pps_in),
    .sec_count(w8_count), .sec_valid(w8_valid),
    .span_sum(w8_sum), .span_valid(w8_span_valid));

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [63:0] q32[$];
  logic [63:0] q8[$];
  logic [63:0] qs32[$];
  logic [63:0] qs8[$];

  int edges_since = 0;
  bit primed = 0;
  longint acc32 = 0, acc8 = 0;
  int n32 = 0, n8 = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic edges(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) osc_in = 1'b1;
      repeat (2) @(negedge clk);
      osc_in = 1'b0;
      repeat (3) @(negedge clk);
    end
    edges_since += n;
  endtask

  task automatic push_expected();
    int v;
    v = edges_since;
    if (primed) begin
      q32.push_back(64'(v));
      q8.push_back(64'(v % 256));
      acc32 += v; n32++;
      if (n32 == 4) begin qs32.push_back(64'(acc32)); acc32 = 0; n32 = 0; end
      acc8 += v % 256; n8++;
      if (n8 == 2) begin qs8.push_back(64'(acc8)); acc8 = 0; n8 = 0; end
    end
  endtask

  task automatic pulse(int high_edges);
    bit was_primed;
    @(negedge clk) pps_in = 1'b1;
    push_expected();
    was_primed = primed;
    primed = 1;
    edges_since = 0;
    repeat (3) @(posedge clk);
    #1;
    check(was_primed ? "R5 latency" : "R6 first capture silent",
          64'(sec_valid), 64'(was_primed));
    if (high_edges > 0) edges(high_edges);
    else repeat (4) @(negedge clk);
    @(negedge clk) pps_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sec_valid) begin
        if (q32.size() == 0) check("R2 unexpected capture", 64'(sec_count), 64'hFFFF);
        else check("R3 R4 count", 64'(sec_count), q32.pop_front());
      end
      if (w8_valid) begin
        if (q8.size() == 0) check("R2 unexpected capture w8", 64'(w8_count), 64'hFFFF);
        else check("R3 wrap count", 64'(w8_count), q8.pop_front());
      end
      if (span_valid) begin
        if (qs32.size() == 0) check("R7 unexpected span", 64'(span_sum), 64'hFFFF);
        else check("R7 span sum", 64'(span_sum), qs32.pop_front());
      end
      if (w8_span_valid) begin
        if (qs8.size() == 0) check("R7 unexpected span w8", 64'(w8_sum), 64'hFFFF);
        else check("R7 span sum w8", 64'(w8_sum), qs8.pop_front());
      end
    end
  end

  initial begin
    #4_000_000;
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset count", 64'(sec_count), 64'd0);
    check("R8 reset span", 64'(span_sum), 64'd0);
    check("R8 reset strobes", 64'({sec_valid, span_valid, w8_valid, w8_span_valid}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 after reset", 64'({sec_valid, sec_count}), 64'd0);

    edges(5);
    pulse(0);       // R6 first capture primes only
    edges(20);
    pulse(0);       // R1 R4 typical
    edges(1);
    pulse(0);
    pulse(0);       // R4 empty interval
    edges(300);
    pulse(0);       // R3 wraps the 8-bit instance
    edges(7);
    pulse(12);      // R2 long high with edges, counted next interval
    edges(3);
    pulse(0);
    edges(37);
    pulse(9);       // R2 R4
    pulse(0);
    edges(256);
    pulse(0);       // R3 exact wrap gives 0 on 8 bits

    repeat (10) @(negedge clk);
    check("R7 R4 queues drained", 64'(q32.size() + q8.size() + qs32.size() + qs8.size()), 64'd0);
    finish_run();
  end

endmodule